// File: doc/BRIEF.md
# Shadow Stack Instruction Unit

This unit executes the shadow-stack instructions of a processor that protects return addresses against corruption. It owns the shadow-stack pointer register and carries out four operations: push a register value onto the stack, pop the top entry and check it against a register value, copy the pointer into a destination register, and atomically exchange a word or doubleword in shadow-stack memory. Instruction decode, the register file and address translation stay outside; the unit receives operand values and the current mode flags and returns a result or an exception cause with its trap value.

An operation is accepted when `req_valid` and `req_ready` are both high. Operations that never touch memory (pointer reads and every operation refused by the legality checks) complete one cycle after acceptance. Memory operations issue a single request pulse on the memory port, wait for the response, and complete one cycle after it arrives. Exactly one `done_valid` or `exc_valid` pulse follows each accepted operation, and the pointer only changes when an operation completes without a trap, or when it is written through its load port.

Top module: `sstk_unit`

## Requirements
- R1: The entry size is 8 bytes when `req_mode64` is 1 and 4 bytes when it is 0; a stack or swap address not aligned to the access size raises cause 6 with the address as trap value, issues no memory request and leaves the pointer unchanged.
- R2: A push stores the source value (its low 32 bits in 32-bit mode) at pointer minus entry size; on a clean response the pointer takes that address and done reports result 0.
- R3: A pop-check loads the entry at the pointer; when it equals the source value (low 32 bits compared in 32-bit mode) the pointer advances by the entry size and done reports result 0.
- R4: A pop-check mismatch raises cause 18 with trap value 3 and leaves the pointer unchanged.
- R5: A pointer read returns the pointer in the result; destination index 0 makes it illegal (cause 2, trap value 0).
- R6: With `req_ss_en` low, push, pop-check, pointer read and both swaps raise cause 2 with trap value 0 and touch no memory; operation codes 5 to 7 are always illegal.
- R7: A swap with `req_priv` equal to 3 raises cause 7 with the swap address as trap value and no memory request; this check takes precedence over the enable check.
- R8: Operation codes are push 0, pop-check 1, pointer read 2, word swap 3, doubleword swap 4. A word swap writes the low 32 bits of the source and returns the old word sign-extended in 64-bit mode and zero-extended in 32-bit mode; a doubleword swap returns all 64 old bits and is illegal (cause 2, checked before every other check) in 32-bit mode.
- R9: A memory response with `mem_rsp_fault` high raises cause 7 with the access address as trap value for any operation, the pop-check load included, and leaves the pointer unchanged.
- R10: `req_ready` is low from acceptance of a memory operation until its completion, the memory request lasts one cycle, and each accepted operation yields exactly one done or exception pulse.
- R11: A pulse on `ptr_set_valid` while idle loads `ptr_set_data` into the pointer, visible on `ptr_value` the next cycle.
- R12: In 32-bit mode pointer arithmetic, addresses and pointer reads use the low 32 bits with the upper half zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Unit idle, request is taken this cycle |
| req_op | input | 3 | Operation code |
| req_src | input | XLEN | Source register value |
| req_addr | input | XLEN | Swap address |
| req_rd | input | RIDX_W | Destination register index |
| req_mode64 | input | 1 | 64-bit register width in effect |
| req_priv | input | 2 | Privilege level, 3 is machine mode |
| req_ss_en | input | 1 | Shadow stacks enabled |
| ptr_set_valid | input | 1 | Write the pointer |
| ptr_set_data | input | XLEN | Value written to the pointer |
| ptr_value | output | XLEN | Current pointer |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | Request writes memory |
| mem_req_swap | output | 1 | Request is an atomic exchange |
| mem_req_dword | output | 1 | 8-byte access, else 4-byte |
| mem_req_ss | output | 1 | Marks the request as a shadow-stack access |
| mem_req_addr | output | XLEN | Access address |
| mem_req_wdata | output | XLEN | Write data |
| mem_rsp_valid | input | 1 | Response arrives |
| mem_rsp_fault | input | 1 | Access faulted |
| mem_rsp_rdata | input | XLEN | Loaded or old data, word accesses in the low half |
| done_valid | output | 1 | Successful completion pulse |
| done_result | output | XLEN | Destination value |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 5 | Exception cause |
| exc_tval | output | XLEN | Trap value |

## Verification
The hardest states to reach are the ones where a trap arrives after the memory has already been asked: a pop-check whose load faults, and a pop-check whose load returns a value that differs from the register only in bits that 32-bit mode must ignore. The bench's memory model answers with a random latency and injects faults on demand, and the pop-check stimulus draws its source from the model's own copy of the stack top half of the time, sometimes flipping only upper bits, so matches, mismatches and faulted loads all occur with the pointer both aligned and deliberately misaligned.

// File: rtl/sstk_pkg.sv
package sstk_pkg;

  localparam logic [2:0] OP_PUSH   = 3'd0;
  localparam logic [2:0] OP_POPCHK = 3'd1;
  localparam logic [2:0] OP_RDPTR  = 3'd2;
  localparam logic [2:0] OP_SWAPW  = 3'd3;
  localparam logic [2:0] OP_SWAPD  = 3'd4;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL    = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_MISALGN = 5'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT   = 5'd7;
  localparam logic [CAUSE_W-1:0] CAUSE_SW_CHECK   = 5'd18;

  localparam int TVAL_RET_VIOLATION = 3;

  typedef enum logic [2:0] {
    OUT_MEM,
    OUT_DONE,
    OUT_ILLEGAL,
    OUT_FAULT,
    OUT_MISALIGN
  } outcome_e;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_LOAD,
    ACC_STORE,
    ACC_SWAP
  } acc_e;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } state_e;

endpackage

// File: rtl/sstk_decode.sv
module sstk_decode
  import sstk_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5
) (
  input  logic [2:0]        op,
  input  logic [XLEN-1:0]   src,
  input  logic [XLEN-1:0]   addr_in,
  input  logic [XLEN-1:0]   ptr,
  input  logic [RIDX_W-1:0] rd,
  input  logic              mode64,
  input  logic [1:0]        priv,
  input  logic              en,
  output outcome_e          outcome,
  output acc_e              acc_kind,
  output logic              acc_dword,
  output logic [XLEN-1:0]   acc_addr,
  output logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   new_ptr,
  output logic [XLEN-1:0]   rd_value
);

  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] STEP64 = XLEN'(8);
  localparam logic [XLEN-1:0] STEP32 = XLEN'(4);

  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] step;
  logic [XLEN-1:0] ptr_m;
  logic            is_swap;
  logic            op_known;
  logic            align_bad;

  assign mask     = mode64 ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign step     = mode64 ? STEP64 : STEP32;
  assign ptr_m    = ptr & mask;
  assign is_swap  = (op == OP_SWAPW) || (op == OP_SWAPD);
  assign op_known = (op <= OP_SWAPD);
  assign rd_value = ptr_m;

  always_comb begin
    acc_kind  = ACC_NONE;
    acc_dword = mode64;
    acc_addr  = ptr_m;
    new_ptr   = ptr_m;
    unique case (op)
      OP_PUSH: begin
        acc_kind = ACC_STORE;
        acc_addr = (ptr_m - step) & mask;
        new_ptr  = (ptr_m - step) & mask;
      end
      OP_POPCHK: begin
        acc_kind = ACC_LOAD;
        new_ptr  = (ptr_m + step) & mask;
      end
      OP_SWAPW: begin
        acc_kind  = ACC_SWAP;
        acc_dword = 1'b0;
        acc_addr  = addr_in & mask;
      end
      OP_SWAPD: begin
        acc_kind  = ACC_SWAP;
        acc_dword = 1'b1;
        acc_addr  = addr_in & mask;
      end
      default: acc_kind = ACC_NONE;
    endcase
  end

  assign wdata     = acc_dword ? src : {{HALF{1'b0}}, src[HALF-1:0]};
  assign align_bad = acc_dword ? (|acc_addr[2:0]) : (|acc_addr[1:0]);

  // Priority of the legality checks
  always_comb begin
    if (!op_known) begin
      outcome = OUT_ILLEGAL;
    end else if ((op == OP_SWAPD) && !mode64) begin
      outcome = OUT_ILLEGAL;
    end else if (is_swap && (priv == 2'b11)) begin
      outcome = OUT_FAULT;
    end else if (!en) begin
      outcome = OUT_ILLEGAL;
    end else if (op == OP_RDPTR) begin
      outcome = (rd == '0) ? OUT_ILLEGAL : OUT_DONE;
    end else if (align_bad) begin
      outcome = OUT_MISALIGN;
    end else begin
      outcome = OUT_MEM;
    end
  end

endmodule

// File: rtl/sstk_ptr.sv
module sstk_ptr #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_valid,
  input  logic [XLEN-1:0] set_data,
  input  logic            upd_valid,
  input  logic [XLEN-1:0] upd_data,
  output logic [XLEN-1:0] ptr_q
);

  logic [XLEN-1:0] ptr_d;
  logic            ptr_en;

  assign ptr_en = upd_valid || set_valid;

  always_comb begin
    ptr_d = ptr_q;
    if (upd_valid) begin
      ptr_d = upd_data;
    end else if (set_valid) begin
      ptr_d = set_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assert_ptr_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && !upd_valid) |=> (ptr_q == $past(set_data)));

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_valid && !upd_valid) |=> $stable(ptr_q));

endmodule

// File: rtl/sstk_ctrl.sv
module sstk_ctrl
  import sstk_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         op,
  input  logic [XLEN-1:0]    src,
  input  logic               mode64,
  input  outcome_e           outcome,
  input  acc_e               acc_kind,
  input  logic               acc_dword,
  input  logic [XLEN-1:0]    acc_addr,
  input  logic [XLEN-1:0]    wdata,
  input  logic [XLEN-1:0]    new_ptr,
  input  logic [XLEN-1:0]    rd_value,
  output logic               mem_req_valid,
  output logic               mem_req_write,
  output logic               mem_req_swap,
  output logic               mem_req_dword,
  output logic [XLEN-1:0]    mem_req_addr,
  output logic [XLEN-1:0]    mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_fault,
  input  logic [XLEN-1:0]    mem_rsp_rdata,
  output logic               ptr_upd_valid,
  output logic [XLEN-1:0]    ptr_upd_data,
  output logic               done_valid,
  output logic [XLEN-1:0]    done_result,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval
);

  localparam int HALF = XLEN / 2;

  state_e             state_q, state_d;
  logic [2:0]         op_q;
  logic [XLEN-1:0]    src_q;
  logic [XLEN-1:0]    addr_q;
  logic [XLEN-1:0]    wdata_q;
  logic [XLEN-1:0]    nptr_q;
  logic               m64_q;
  logic               write_q;
  logic               swap_q;
  logic               dword_q;
  logic               ctx_en;
  logic               mreq_q, mreq_d;
  logic               done_q, done_d;
  logic               exc_q, exc_d;
  logic [XLEN-1:0]    result_q, result_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [XLEN-1:0]    tval_q, tval_d;
  logic               out_en;
  logic               entry_match;
  logic [XLEN-1:0]    swapw_value;

  assign entry_match = m64_q ? (mem_rsp_rdata == src_q)
                             : (mem_rsp_rdata[HALF-1:0] == src_q[HALF-1:0]);
  assign swapw_value = m64_q ? {{HALF{mem_rsp_rdata[HALF-1]}}, mem_rsp_rdata[HALF-1:0]}
                             : {{HALF{1'b0}}, mem_rsp_rdata[HALF-1:0]};

  always_comb begin
    state_d       = state_q;
    ctx_en        = 1'b0;
    mreq_d        = 1'b0;
    done_d        = 1'b0;
    exc_d         = 1'b0;
    result_d      = result_q;
    cause_d       = cause_q;
    tval_d        = tval_q;
    ptr_upd_valid = 1'b0;
    ptr_upd_data  = nptr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          unique case (outcome)
            OUT_MEM: begin
              ctx_en  = 1'b1;
              mreq_d  = 1'b1;
              state_d = ST_WAIT;
            end
            OUT_DONE: begin
              done_d   = 1'b1;
              result_d = rd_value;
            end
            OUT_FAULT: begin
              exc_d   = 1'b1;
              cause_d = CAUSE_ST_FAULT;
              tval_d  = acc_addr;
            end
            OUT_MISALIGN: begin
              exc_d   = 1'b1;
              cause_d = CAUSE_ST_MISALGN;
              tval_d  = acc_addr;
            end
            default: begin
              exc_d   = 1'b1;
              cause_d = CAUSE_ILLEGAL;
              tval_d  = '0;
            end
          endcase
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          if (mem_rsp_fault) begin
            exc_d   = 1'b1;
            cause_d = CAUSE_ST_FAULT;
            tval_d  = addr_q;
          end else begin
            unique case (op_q)
              OP_PUSH: begin
                done_d        = 1'b1;
                result_d      = '0;
                ptr_upd_valid = 1'b1;
              end
              OP_POPCHK: begin
                if (entry_match) begin
                  done_d        = 1'b1;
                  result_d      = '0;
                  ptr_upd_valid = 1'b1;
                end else begin
                  exc_d   = 1'b1;
                  cause_d = CAUSE_SW_CHECK;
                  tval_d  = XLEN'(TVAL_RET_VIOLATION);
                end
              end
              OP_SWAPW: begin
                done_d   = 1'b1;
                result_d = swapw_value;
              end
              default: begin
                done_d   = 1'b1;
                result_d = mem_rsp_rdata;
              end
            endcase
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign out_en = done_d || exc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mreq_q  <= 1'b0;
      done_q  <= 1'b0;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mreq_q  <= mreq_d;
      done_q  <= done_d;
      exc_q   <= exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      src_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      nptr_q  <= '0;
      m64_q   <= 1'b0;
      write_q <= 1'b0;
      swap_q  <= 1'b0;
      dword_q <= 1'b0;
    end else if (ctx_en) begin
      op_q    <= op;
      src_q   <= src;
      addr_q  <= acc_addr;
      wdata_q <= wdata;
      nptr_q  <= new_ptr;
      m64_q   <= mode64;
      write_q <= (acc_kind != ACC_LOAD);
      swap_q  <= (acc_kind == ACC_SWAP);
      dword_q <= acc_dword;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      cause_q  <= '0;
      tval_q   <= '0;
    end else if (out_en) begin
      result_q <= result_d;
      cause_q  <= cause_d;
      tval_q   <= tval_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = mreq_q;
  assign mem_req_write = write_q;
  assign mem_req_swap  = swap_q;
  assign mem_req_dword = dword_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;
  assign done_valid    = done_q;
  assign done_result   = result_q;
  assign exc_valid     = exc_q;
  assign exc_cause     = cause_q;
  assign exc_tval      = tval_q;

  assert_req_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_dword ? (mem_req_addr[2:0] == 3'b000)
                                     : (mem_req_addr[1:0] == 2'b00)));

  assert_busy_while_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_req_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  assert_no_result_with_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !(done_valid || exc_valid));

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_valid, exc_valid}));

endmodule

// File: rtl/sstk_unit.sv
module sstk_unit
  import sstk_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [XLEN-1:0]    req_src,
  input  logic [XLEN-1:0]    req_addr,
  input  logic [RIDX_W-1:0]  req_rd,
  input  logic               req_mode64,
  input  logic [1:0]         req_priv,
  input  logic               req_ss_en,
  input  logic               ptr_set_valid,
  input  logic [XLEN-1:0]    ptr_set_data,
  output logic [XLEN-1:0]    ptr_value,
  output logic               mem_req_valid,
  output logic               mem_req_write,
  output logic               mem_req_swap,
  output logic               mem_req_dword,
  output logic               mem_req_ss,
  output logic [XLEN-1:0]    mem_req_addr,
  output logic [XLEN-1:0]    mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_fault,
  input  logic [XLEN-1:0]    mem_rsp_rdata,
  output logic               done_valid,
  output logic [XLEN-1:0]    done_result,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval
);

  outcome_e        dec_outcome;
  acc_e            dec_kind;
  logic            dec_dword;
  logic [XLEN-1:0] dec_addr;
  logic [XLEN-1:0] dec_wdata;
  logic [XLEN-1:0] dec_nptr;
  logic [XLEN-1:0] dec_rdval;
  logic            upd_valid;
  logic [XLEN-1:0] upd_data;

  sstk_decode #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_decode (
    .op       (req_op),
    .src      (req_src),
    .addr_in  (req_addr),
    .ptr      (ptr_value),
    .rd       (req_rd),
    .mode64   (req_mode64),
    .priv     (req_priv),
    .en       (req_ss_en),
    .outcome  (dec_outcome),
    .acc_kind (dec_kind),
    .acc_dword(dec_dword),
    .acc_addr (dec_addr),
    .wdata    (dec_wdata),
    .new_ptr  (dec_nptr),
    .rd_value (dec_rdval)
  );

  sstk_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .op           (req_op),
    .src          (req_src),
    .mode64       (req_mode64),
    .outcome      (dec_outcome),
    .acc_kind     (dec_kind),
    .acc_dword    (dec_dword),
    .acc_addr     (dec_addr),
    .wdata        (dec_wdata),
    .new_ptr      (dec_nptr),
    .rd_value     (dec_rdval),
    .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write),
    .mem_req_swap (mem_req_swap),
    .mem_req_dword(mem_req_dword),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_fault(mem_rsp_fault),
    .mem_rsp_rdata(mem_rsp_rdata),
    .ptr_upd_valid(upd_valid),
    .ptr_upd_data (upd_data),
    .done_valid   (done_valid),
    .done_result  (done_result),
    .exc_valid    (exc_valid),
    .exc_cause    (exc_cause),
    .exc_tval     (exc_tval)
  );

  sstk_ptr #(.XLEN(XLEN)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_valid(ptr_set_valid),
    .set_data (ptr_set_data),
    .upd_valid(upd_valid),
    .upd_data (upd_data),
    .ptr_q    (ptr_value)
  );

  assign mem_req_ss = mem_req_valid;

  assert_trap_keeps_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !$past(ptr_set_valid)) |-> (ptr_value == $past(ptr_value)));

  assert_no_mem_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_ss_en) |=> !mem_req_valid);

  assert_mmode_swap_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_priv == 2'b11) &&
     ((req_op == OP_SWAPW) || (req_op == OP_SWAPD))) |=> !mem_req_valid);

endmodule

// File: tb/test_sstk_unit.sv
module test_sstk_unit;

  localparam int XLEN = 64;
  localparam int RIDX_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_op = '0;
  logic [XLEN-1:0]   req_src = '0;
  logic [XLEN-1:0]   req_addr = '0;
  logic [RIDX_W-1:0] req_rd = '0;
  logic              req_mode64 = 1'b1;
  logic [1:0]        req_priv = 2'b00;
  logic              req_ss_en = 1'b1;
  logic              ptr_set_valid = 1'b0;
  logic [XLEN-1:0]   ptr_set_data = '0;
  logic [XLEN-1:0]   ptr_value;
  logic              mem_req_valid, mem_req_write, mem_req_swap, mem_req_dword, mem_req_ss;
  logic [XLEN-1:0]   mem_req_addr, mem_req_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic              mem_rsp_fault = 1'b0;
  logic [XLEN-1:0]   mem_rsp_rdata = '0;
  logic              done_valid, exc_valid;
  logic [XLEN-1:0]   done_result, exc_tval;
  logic [4:0]        exc_cause;

  int checks = 0;
  int failures = 0;
  int req_count = 0;
  bit inject_fault = 1'b0;
  bit finished = 1'b0;
  logic [63:0] smem [0:31];

  always #2 clk = ~clk;

  sstk_unit #(.XLEN(XLEN), .RIDX_W(RIDX_W)) i_sstk_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src(req_src), .req_addr(req_addr), .req_rd(req_rd),
    .req_mode64(req_mode64), .req_priv(req_priv), .req_ss_en(req_ss_en),
    .ptr_set_valid(ptr_set_valid), .ptr_set_data(ptr_set_data), .ptr_value(ptr_value),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .mem_req_swap(mem_req_swap),
    .mem_req_dword(mem_req_dword), .mem_req_ss(mem_req_ss), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_fault(mem_rsp_fault),
    .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid), .done_result(done_result),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_read(input logic [63:0] a, input bit dw);
    logic [63:0] w;
    w = smem[a[7:3]];
    if (dw) return w;
    return a[2] ? {32'h0, w[63:32]} : {32'h0, w[31:0]};
  endfunction

  // memory model with random latency and fault injection
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [63:0] a, wd;
        bit wr, dw, flt;
        a = mem_req_addr; wd = mem_req_wdata; wr = mem_req_write;
        dw = mem_req_dword; flt = inject_fault;
        req_count++;
        chk("R10 shadow-stack mark", {63'h0, mem_req_ss}, 64'h1);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_fault = flt;
        mem_rsp_rdata = flt ? {$urandom, $urandom} : mem_read(a, dw);
        if (wr && !flt) begin
          if (dw) smem[a[7:3]] = wd;
          else if (a[2]) smem[a[7:3]][63:32] = wd[31:0];
          else smem[a[7:3]][31:0] = wd[31:0];
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_fault = 1'b0;
      end
    end
  end

  task automatic set_ptr(input logic [63:0] v);
    @(negedge clk);
    ptr_set_valid = 1'b1; ptr_set_data = v;
    @(negedge clk);
    ptr_set_valid = 1'b0;
    chk("R11 pointer load", ptr_value, v);
  endtask

  // issue one operation and compare with the model
  task automatic run_op(input logic [2:0] op, input logic [63:0] src, input logic [63:0] addr,
                        input logic [4:0] rd, input bit m64, input logic [1:0] priv,
                        input bit en, input bit flt, input string tag);
    logic [63:0] mask, step, p, a, exp_res, exp_tval, exp_ptr, old;
    logic [4:0] exp_cause;
    bit exp_exc, mem_op, dw, mis;
    int reqs0, wait_n;
    mask = m64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    step = m64 ? 64'd8 : 64'd4;
    p = ptr_value & mask;
    exp_exc = 1'b0; exp_res = 0; exp_cause = 0; exp_tval = 0; exp_ptr = ptr_value; mem_op = 1'b0;
    dw = (op == 3'd4) ? 1'b1 : (op == 3'd3) ? 1'b0 : m64;
    a = (op == 3'd0) ? ((p - step) & mask) : (op >= 3'd3) ? (addr & mask) : p;
    mis = dw ? (a[2:0] != 0) : (a[1:0] != 0);
    if (op > 3'd4 || (op == 3'd4 && !m64)) begin exp_exc = 1; exp_cause = 5'd2; end
    else if (op >= 3'd3 && priv == 2'b11) begin exp_exc = 1; exp_cause = 5'd7; exp_tval = a; end
    else if (!en) begin exp_exc = 1; exp_cause = 5'd2; end
    else if (op == 3'd2) begin
      if (rd == 0) begin exp_exc = 1; exp_cause = 5'd2; end
      else exp_res = p;
    end
    else if (mis) begin exp_exc = 1; exp_cause = 5'd6; exp_tval = a; end
    else begin
      mem_op = 1'b1;
      old = mem_read(a, dw);
      if (flt) begin exp_exc = 1; exp_cause = 5'd7; exp_tval = a; end
      else if (op == 3'd0) exp_ptr = a;
      else if (op == 3'd1) begin
        if ((old & mask) == (src & mask)) exp_ptr = (p + step) & mask;
        else begin exp_exc = 1; exp_cause = 5'd18; exp_tval = 64'd3; end
      end
      else if (op == 3'd3) exp_res = m64 ? {{32{old[31]}}, old[31:0]} : {32'h0, old[31:0]};
      else exp_res = old;
    end
    reqs0 = req_count;
    @(negedge clk);
    inject_fault = flt;
    req_valid = 1'b1; req_op = op; req_src = src; req_addr = addr; req_rd = rd;
    req_mode64 = m64; req_priv = priv; req_ss_en = en;
    chk({tag, " ready idle"}, {63'h0, req_ready}, 64'h1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_n = 0;
    while (!(done_valid || exc_valid) && wait_n < 40) begin
      if (mem_op) chk("R10 ready low while busy", {63'h0, req_ready}, 64'h0);
      @(negedge clk);
      wait_n++;
    end
    chk({tag, " exception flag"}, {63'h0, exc_valid}, {63'h0, exp_exc});
    if (exp_exc) begin
      chk({tag, " cause"}, {59'h0, exc_cause}, {59'h0, exp_cause});
      chk({tag, " tval"}, exc_tval, exp_tval);
    end else begin
      chk({tag, " result"}, done_result, exp_res);
    end
    chk({tag, " pointer"}, ptr_value, exp_ptr);
    chk({tag, " request count"}, 64'(req_count - reqs0), mem_op ? 64'd1 : 64'd0);
    if (!exp_exc && op == 3'd0) chk("R2 pushed value", mem_read(a, dw), src & mask);
    @(negedge clk);
    chk("R10 single pulse", {62'h0, done_valid, exc_valid}, 64'h0);
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R8";
      3'd4: return "R8";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) smem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset idle", {61'h0, req_ready, done_valid, exc_valid}, 64'h4);
    chk("R11 reset pointer", ptr_value, 64'h0);

    // directed corner cases
    set_ptr(64'h80);
    run_op(3'd0, 64'h1122_3344_5566_7788, 0, 1, 1, 0, 1, 0, "R2 push 64");
    run_op(3'd1, 64'h1122_3344_5566_7788, 0, 1, 1, 0, 1, 0, "R3 pop match");
    run_op(3'd0, 64'hA5A5, 0, 1, 1, 0, 1, 0, "R2 push again");
    run_op(3'd1, 64'hA5A4, 0, 1, 1, 0, 1, 0, "R4 pop mismatch");
    run_op(3'd1, 64'hA5A5, 0, 1, 1, 0, 1, 1, "R9 pop load fault");
    run_op(3'd2, 0, 0, 5, 1, 0, 1, 0, "R5 read pointer");
    run_op(3'd2, 0, 0, 0, 1, 0, 1, 0, "R5 rd zero");
    for (int op = 0; op < 5; op++) run_op(3'(op), 0, 64'h40, 3, 1, 1, 0, 0, "R6 disabled");
    run_op(3'd6, 0, 0, 3, 1, 0, 1, 0, "R6 unknown op");
    run_op(3'd3, 0, 64'h40, 3, 1, 2'b11, 0, 0, "R7 machine swap");
    run_op(3'd4, 0, 64'h40, 3, 0, 2'b11, 1, 0, "R8 dword swap in 32-bit");
    smem[8] = 64'h0000_0000_8000_0001;
    run_op(3'd3, 64'h7, 64'h40, 3, 1, 0, 1, 0, "R8 word swap sign");
    run_op(3'd3, 64'h9, 64'h40, 3, 0, 0, 1, 0, "R12 word swap 32-bit");
    run_op(3'd4, 64'hDEAD_BEEF_0000_0001, 64'h48, 3, 1, 0, 1, 0, "R8 dword swap");
    run_op(3'd4, 64'h1, 64'h44, 3, 1, 0, 1, 0, "R1 swap misaligned");
    run_op(3'd0, 64'h55, 0, 1, 1, 0, 1, 1, "R9 push fault");
    set_ptr(64'hFFFF_FFFF_0000_0084);
    run_op(3'd2, 0, 0, 7, 0, 0, 1, 0, "R12 read pointer 32-bit");
    run_op(3'd0, 64'hFFFF_0000_1234_5678, 0, 1, 0, 0, 1, 0, "R12 push 32-bit");
    run_op(3'd1, 64'h0000_FFFF_1234_5678, 0, 1, 0, 0, 1, 0, "R12 pop 32-bit upper ignored");
    set_ptr(64'h84);
    run_op(3'd0, 64'h1, 0, 1, 1, 0, 1, 0, "R1 push misaligned");
    run_op(3'd1, 64'h1, 0, 1, 1, 0, 1, 0, "R1 pop misaligned");

    // constrained random
    for (int n = 0; n < 500; n++) begin
      logic [2:0] op;
      logic [63:0] src, addr;
      bit m64, en, flt;
      logic [1:0] priv;
      int sel;
      if (n % 25 == 0) set_ptr(($urandom_range(0, 9) == 0) ? 64'(8'h62 + 2 * $urandom_range(0, 3))
                                                             : 64'(8'h60 + 8 * $urandom_range(0, 8)));
      sel = $urandom_range(0, 99);
      op = (sel < 30) ? 3'd0 : (sel < 60) ? 3'd1 : (sel < 70) ? 3'd2 : (sel < 83) ? 3'd3 :
           (sel < 96) ? 3'd4 : 3'(5 + $urandom_range(0, 2));
      m64 = ($urandom_range(0, 3) != 0);
      en = ($urandom_range(0, 9) != 0);
      flt = ($urandom_range(0, 9) == 0);
      priv = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'(($urandom_range(0, 1)));
      addr = 64'(8 * $urandom_range(0, 31) + (($urandom_range(0, 7) == 0) ? 2 : 4 * $urandom_range(0, 1)));
      src = {$urandom, $urandom};
      if (op == 3'd1 && $urandom_range(0, 1) == 1) begin
        src = mem_read(ptr_value & (m64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF), m64);
        if ($urandom_range(0, 3) == 0) src[40] = ~src[40];
      end
      run_op(op, src, addr, 5'($urandom_range(0, 3)), m64, priv, en, flt, tag_of(op));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule